// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Arbiter

This block decides, cycle by cycle, which warp instructions leave the two warp schedulers of one multiprocessor slice and which execution column each one enters. Each scheduler port offers at most one instruction per cycle. The instruction carries a class code and the ID of its warp. The arbiter looks at which of the four columns are free and grants up to two instructions in the same cycle. It then raises one issue strobe, with the warp ID, on every column it has just loaded. The four columns are two 16-lane core columns, one 16-lane load/store column and one 4-lane special-function column.

A column stays occupied for as many cycles as it needs to pass all 32 threads of a warp through its lanes. A double-precision operation takes both core columns and issues alone. The special-function column is slow, but a warp waiting for it does not hold back the other port. When both ports want the same single resource, a one-bit pointer decides the winner. The pointer moves only when such a clash occurs, so the two schedulers take turns. A port that loses sees its stall output and keeps its instruction on the inputs until it is granted. All outputs are combinational from the registered column state in the same cycle as the request.

Top module: `warp_issue_arb`

## Requirements
- R1: After reset every column is idle and the alternation pointer favours port 0. With no request there is no grant, no stall and no strobe, and the first clash is won by port 0.
- R2: The class codes are 0 = integer/single-precision core op, 1 = load/store, 2 = special-function and 3 = double-precision. A granted core op goes to core column 0 (strobe bit 0) if that column is free and to core column 1 (bit 1) otherwise. When both ports issue core ops together, port 0 takes column 0 and port 1 takes column 1. Strobe bit 2 is load/store and bit 3 is special-function. Each strobed column shows the warp ID of the port it serves.
- R3: Two valid requests whose needs fall on distinct free columns are both granted in the same cycle, for example core+core, core+load/store or load/store+special-function. No more than two column strobes are ever active.
- R4: A granted double-precision op strobes both core columns with its own warp ID and is the only grant in that cycle. Both core columns must be free for it.
- R5: A core or load/store column that issues in cycle t cannot issue in cycle t+1 and is free again in cycle t+2. A strobe never goes to a busy column.
- R6: The special-function column that issues in cycle t stays busy through cycle t+7 and is free in cycle t+8. While it is busy, the other port keeps issuing to the other columns.
- R7: When both requests could each be served but not together, the favoured port is granted and the pointer then favours the other port, so repeated clashes alternate.
- R8: When a request cannot be served because its column is busy, the other port is granted without a clash and the pointer does not move.
- R9: A port is never granted without its valid input. Stall equals valid and not granted, and an invalid port's class and warp inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Per-port request valid, bit p for port p |
| req_class | input | 4 | Per-port class code, bits [2p+1:2p] |
| req_warp | input | 2*WARP_W | Per-port warp ID, slice p |
| grant | output | 2 | Per-port grant this cycle |
| stall | output | 2 | Per-port stall: valid but not granted |
| col_issue | output | 4 | Issue strobe per column: 0,1 core, 2 load/store, 3 special-function |
| col_warp | output | 4*WARP_W | Warp ID presented with each column strobe, slice c |

## Verification
The properties assume that a stalled port keeps its request stable and that class code 3 marks the only double-precision form. Nothing else limits the inputs: any mix of valid bits and classes is legal, and the properties hold for all of them. The stimulus presents one-cycle request patterns with every column idle, separated by long idle gaps. It then holds requests stable across busy windows, so that the occupancy timing, the stalls and the pointer history stay known at every step.

// File: rtl/wia_pkg.sv
package wia_pkg;

  typedef enum logic [1:0] {
    OP_CORE = 2'd0,
    OP_LDST = 2'd1,
    OP_SFU  = 2'd2,
    OP_DP   = 2'd3
  } op_class_e;

  localparam int NPORT  = 2;
  localparam int NCOL   = 4;
  localparam int COL_CA = 0;
  localparam int COL_CB = 1;
  localparam int COL_LS = 2;
  localparam int COL_SF = 3;

  // Can an op of this class be placed on the given free columns?
  function automatic logic op_fits(op_class_e c, logic [NCOL-1:0] free);
    case (c)
      OP_CORE: op_fits = free[COL_CA] | free[COL_CB];
      OP_LDST: op_fits = free[COL_LS];
      OP_SFU:  op_fits = free[COL_SF];
      default: op_fits = free[COL_CA] & free[COL_CB];
    endcase
  endfunction

endpackage

// File: rtl/wia_col_timer.sv
module wia_col_timer #(
  parameter int BUSY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic free
);
  localparam int CW = (BUSY > 1) ? $clog2(BUSY) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = issue | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (issue) begin
      cnt_d = CW'(BUSY - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign free = (cnt_q == '0);

endmodule

// File: rtl/wia_pair_arb.sv
module wia_pair_arb
  import wia_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req_valid,
  input  logic [2*NPORT-1:0] req_class,
  input  logic [NCOL-1:0]  col_free,
  output logic [NPORT-1:0] grant
);
  op_class_e cls0, cls1;
  logic      feas0, feas1;
  logic      pair_ok, clash;
  logic      rr_q, rr_d, rr_en;

  always_comb begin
    cls0  = op_class_e'(req_class[1:0]);
    cls1  = op_class_e'(req_class[3:2]);
    feas0 = req_valid[0] & op_fits(cls0, col_free);
    feas1 = req_valid[1] & op_fits(cls1, col_free);
    if (cls0 == OP_DP || cls1 == OP_DP) begin
      pair_ok = 1'b0;
    end else if (cls0 == OP_CORE && cls1 == OP_CORE) begin
      pair_ok = col_free[COL_CA] & col_free[COL_CB];
    end else begin
      pair_ok = (cls0 != cls1);
    end
    clash = feas0 & feas1 & ~pair_ok;
    rr_en = clash;
    rr_d  = ~rr_q;
    if (clash) begin
      grant = rr_q ? 2'b10 : 2'b01;
    end else begin
      grant = {feas1, feas0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= 1'b0;
    end else if (rr_en) begin
      rr_q <= rr_d;
    end
  end

endmodule

// File: rtl/wia_col_route.sv
module wia_col_route
  import wia_pkg::*;
#(
  parameter int WARP_W = 6
) (
  input  logic [2*NPORT-1:0]      req_class,
  input  logic [NPORT*WARP_W-1:0] req_warp,
  input  logic [NPORT-1:0]        grant,
  input  logic [NCOL-1:0]         col_free,
  output logic [NCOL-1:0]         col_issue,
  output logic [NCOL*WARP_W-1:0]  col_warp
);
  always_comb begin
    col_issue = '0;
    col_warp  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (grant[p]) begin
        case (op_class_e'(req_class[2*p +: 2]))
          OP_CORE: begin
            if (col_free[COL_CA] && !col_issue[COL_CA]) begin
              col_issue[COL_CA] = 1'b1;
              col_warp[COL_CA*WARP_W +: WARP_W] = req_warp[p*WARP_W +: WARP_W];
            end else begin
              col_issue[COL_CB] = 1'b1;
              col_warp[COL_CB*WARP_W +: WARP_W] = req_warp[p*WARP_W +: WARP_W];
            end
          end
          OP_LDST: begin
            col_issue[COL_LS] = 1'b1;
            col_warp[COL_LS*WARP_W +: WARP_W] = req_warp[p*WARP_W +: WARP_W];
          end
          OP_SFU: begin
            col_issue[COL_SF] = 1'b1;
            col_warp[COL_SF*WARP_W +: WARP_W] = req_warp[p*WARP_W +: WARP_W];
          end
          default: begin
            col_issue[COL_CA] = 1'b1;
            col_issue[COL_CB] = 1'b1;
            col_warp[COL_CA*WARP_W +: WARP_W] = req_warp[p*WARP_W +: WARP_W];
            col_warp[COL_CB*WARP_W +: WARP_W] = req_warp[p*WARP_W +: WARP_W];
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/warp_issue_arb.sv
module warp_issue_arb
  import wia_pkg::*;
#(
  parameter int WARP_W     = 6,
  parameter int WARP_SIZE  = 32,
  parameter int CORE_LANES = 16,
  parameter int LDST_LANES = 16,
  parameter int SFU_LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              req_valid,
  input  logic [3:0]              req_class,
  input  logic [2*WARP_W-1:0]     req_warp,
  output logic [1:0]              grant,
  output logic [1:0]              stall,
  output logic [3:0]              col_issue,
  output logic [4*WARP_W-1:0]     col_warp
);
  localparam int CORE_BUSY = WARP_SIZE / CORE_LANES;
  localparam int LDST_BUSY = WARP_SIZE / LDST_LANES;
  localparam int SFU_BUSY  = WARP_SIZE / SFU_LANES;

  logic [NCOL-1:0] col_free;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int BUSY = (c == COL_SF) ? SFU_BUSY :
                          (c == COL_LS) ? LDST_BUSY : CORE_BUSY;
    wia_col_timer #(.BUSY(BUSY)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .issue(col_issue[c]),
      .free (col_free[c])
    );
  end

  wia_pair_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_class(req_class),
    .col_free (col_free),
    .grant    (grant)
  );

  wia_col_route #(.WARP_W(WARP_W)) u_route (
    .req_class(req_class),
    .req_warp (req_warp),
    .grant    (grant),
    .col_free (col_free),
    .col_issue(col_issue),
    .col_warp (col_warp)
  );

  assign stall = req_valid & ~grant;

endmodule

// File: rtl/warp_issue_arb_chk.sv
module warp_issue_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_valid,
  input logic [3:0] req_class,
  input logic [1:0] grant,
  input logic [1:0] stall,
  input logic [3:0] col_issue,
  input logic [3:0] col_free
);
  for (genvar c = 0; c < 4; c++) begin : g_busy
    assert_issue_only_when_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      col_issue[c] |-> col_free[c]);
  end

  assert_ldst_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[2] |=> !col_issue[2]);

  assert_core_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[0] |=> !col_issue[0]);

  assert_sfu_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[3] |=> !col_issue[3]);

  assert_dp_alone_p0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[0] && req_class[1:0] == 2'd3) |-> (grant == 2'b01 && col_issue == 4'b0011));

  assert_dp_alone_p1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[1] && req_class[3:2] == 2'd3) |-> (grant == 2'b10 && col_issue == 4'b0011));

  assert_at_most_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_issue) <= 2);

  assert_grant_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == 2'b00);

  assert_issue_means_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_issue != 4'b0000) |-> (grant != 2'b00 && stall != 2'b11));

endmodule

bind warp_issue_arb warp_issue_arb_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_class(req_class),
  .grant    (grant),
  .stall    (stall),
  .col_issue(col_issue),
  .col_free (col_free)
);

// File: tb/warp_issue_arb_bench.sv
module warp_issue_arb_bench;
  localparam int WW = 6;
  localparam int NV = 12;

  logic            clk;
  logic            rst_n;
  logic [1:0]      req_valid;
  logic [3:0]      req_class;
  logic [2*WW-1:0] req_warp;
  logic [1:0]      grant;
  logic [1:0]      stall;
  logic [3:0]      col_issue;
  logic [4*WW-1:0] col_warp;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  warp_issue_arb u_warp_issue_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_class(req_class),
    .req_warp (req_warp),
    .grant    (grant),
    .stall    (stall),
    .col_issue(col_issue),
    .col_warp (col_warp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {v0, c0, w0, v1, c1, w1, expected grant, expected strobes}; all columns idle before each
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 2'd0, 6'd3,  1'b0, 2'd0, 6'd0,  2'b01, 4'b0001},  // R2 single core
    {1'b1, 2'd0, 6'd5,  1'b1, 2'd0, 6'd9,  2'b11, 4'b0011},  // R2 R3 core+core
    {1'b1, 2'd0, 6'd10, 1'b1, 2'd1, 6'd11, 2'b11, 4'b0101},  // R3 core+ldst
    {1'b1, 2'd1, 6'd14, 1'b1, 2'd2, 6'd15, 2'b11, 4'b1100},  // R3 ldst+sfu
    {1'b1, 2'd2, 6'd17, 1'b1, 2'd0, 6'd18, 2'b11, 4'b1001},  // R3 sfu+core
    {1'b1, 2'd3, 6'd7,  1'b1, 2'd1, 6'd20, 2'b01, 4'b0011},  // R1 R4 first clash, port 0
    {1'b1, 2'd1, 6'd21, 1'b1, 2'd1, 6'd22, 2'b10, 4'b0100},  // R7 port 1 now
    {1'b1, 2'd2, 6'd23, 1'b1, 2'd2, 6'd24, 2'b01, 4'b1000},  // R7 back to port 0
    {1'b1, 2'd0, 6'd25, 1'b1, 2'd3, 6'd26, 2'b10, 4'b0011},  // R4 R7 dp on port 1
    {1'b1, 2'd3, 6'd27, 1'b0, 2'd1, 6'd28, 2'b01, 4'b0011},  // R4 R9 dp alone
    {1'b0, 2'd2, 6'd29, 1'b0, 2'd3, 6'd30, 2'b00, 4'b0000},  // R9 nothing valid
    {1'b0, 2'd0, 6'd0,  1'b1, 2'd0, 6'd31, 2'b10, 4'b0001}   // R2 port 1 core to column 0
  };

  task automatic check(string req, int got, int exp);
    tests_run++;
    if (got != exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(bit v0, logic [1:0] c0, logic [WW-1:0] w0,
                       bit v1, logic [1:0] c1, logic [WW-1:0] w1);
    @(negedge clk);
    req_valid = {v1, v0};
    req_class = {c1, c0};
    req_warp  = {w1, w0};
    #5;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 2'd0, '0, 0, 2'd0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Expected warp on a strobed column, valid when all columns were idle (R2)
  function automatic int exp_warp(int col, logic [1:0] g, logic [1:0] c0, logic [1:0] c1,
                                  int w0, int w1);
    if (col == 2) return (g[0] && c0 == 2'd1) ? w0 : w1;
    if (col == 3) return (g[0] && c0 == 2'd2) ? w0 : w1;
    if (g[0] && c0 == 2'd3) return w0;
    if (g[1] && c1 == 2'd3) return w1;
    if (g == 2'b11 && c0 == 2'd0 && c1 == 2'd0) return (col == 0) ? w0 : w1;
    return (g[0] && c0 == 2'd0) ? w0 : w1;
  endfunction

  initial begin
    #(20 * 20000);
    if (!done) begin
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 2'b00;
    req_class = 4'b0000;
    req_warp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle(1);
    check("R1 grant idle", grant, 0);
    check("R1 stall idle", stall, 0);
    check("R1 strobes idle", col_issue, 0);

    // Table of one-cycle patterns from an idle state
    for (int n = 0; n < NV; n++) begin
      logic [23:0] v;
      v = VEC[n];
      drive(v[23], v[22:21], v[20:15], v[14], v[13:12], v[11:6]);
      check("R2/R3/R4/R7 grant", grant, v[5:4]);
      check("R9 stall", stall, {v[14], v[23]} & ~v[5:4]);
      check("R2/R4 strobes", col_issue, v[3:0]);
      for (int c = 0; c < 4; c++) begin
        if (v[c])
          check("R2 column warp", col_warp[c*WW +: WW],
                exp_warp(c, v[5:4], v[22:21], v[13:12], v[20:15], v[11:6]));
      end
      idle(8);
    end

    // R5 core and load/store occupancy
    drive(1, 2'd0, 6'd1, 0, 2'd0, '0);
    check("R5 core first to column 0", col_issue, 4'b0001);
    drive(1, 2'd0, 6'd2, 0, 2'd0, '0);
    check("R5 core column 0 busy, uses column 1", col_issue, 4'b0010);
    drive(1, 2'd1, 6'd3, 0, 2'd0, '0);
    check("R5 ldst issue", col_issue, 4'b0100);
    drive(1, 2'd1, 6'd4, 0, 2'd0, '0);
    check("R5 ldst busy stall", stall, 2'b01);
    check("R5 ldst busy no strobe", col_issue, 4'b0000);
    drive(1, 2'd1, 6'd4, 0, 2'd0, '0);
    check("R5 ldst free again", grant, 2'b01);
    check("R5 ldst warp", col_warp[2*WW +: WW], 4);
    idle(8);

    // R6 special-function occupancy, other port keeps issuing (R8: no clash)
    drive(0, 2'd0, '0, 1, 2'd2, 6'd12);
    check("R6 sfu issue", col_issue, 4'b1000);
    for (int k = 1; k < 8; k++) begin
      drive(1, 2'd0, 6'(k), 1, 2'd2, 6'd13);
      check("R6 sfu busy, port 0 granted", grant, 2'b01);
      check("R6 sfu busy stall", stall, 2'b10);
    end
    drive(0, 2'd0, '0, 1, 2'd2, 6'd13);
    check("R6 sfu free at t+8", grant, 2'b10);
    check("R6 sfu warp", col_warp[3*WW +: WW], 13);
    idle(8);

    // R8 pointer unchanged by the non-clash stalls above; R7 alternation
    drive(1, 2'd1, 6'd1, 1, 2'd1, 6'd2);
    check("R8 pointer still port 0", grant, 2'b01);
    idle(1);
    drive(1, 2'd1, 6'd1, 1, 2'd1, 6'd2);
    check("R7 alternate to port 1", grant, 2'b10);
    idle(1);
    drive(1, 2'd1, 6'd1, 1, 2'd1, 6'd2);
    check("R7 alternate to port 0", grant, 2'b01);

    // R1 reset clears the pointer (now favouring port 1) and busy columns
    idle(1);
    drive(0, 2'd0, '0, 1, 2'd2, 6'd5);
    do_reset();
    drive(1, 2'd1, 6'd1, 1, 2'd1, 6'd2);
    check("R1 pointer back to port 0", grant, 2'b01);
    drive(0, 2'd0, '0, 1, 2'd2, 6'd6);
    check("R1 sfu idle after reset", col_issue, 4'b1000);
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule